// File: doc/BRIEF.md
# Scaler Initial Phase Calculator

This unit works out the starting filter phase for one axis of a polyphase image scaler. It takes the source-to-destination ratio in 16.16 fixed point, a chroma subsampling factor and a co-sited flag. It produces the 16-bit word that seeds the scaler's phase accumulator. The phase is measured so that the first output sample lines up with the top-left edge of the source pixel, not with the pixel centre. For that reason the calculation starts half a pixel negative.

The result is not a plain signed number. A negative phase is wrapped into the next unit interval and reported with a cleared trip bit. A non-negative phase keeps its value and sets the trip bit. The low bits carry the phase truncated by two bits, with bit 0 forced to zero.

The unit is a two-stage pipeline with a valid qualifier. The first stage forms the signed phase sum. The second stage checks the range and encodes the word. An input qualified by `vld_i` yields its result exactly two clock cycles later. A range or parameter fault raises `err_o` instead of producing a word.

Top module: `scl_phase_calc`

## Requirements
- R1: After reset, `vld_o` and `err_o` are 0 and `word_o` is 0x0000.
- R2: A sample accepted with `vld_i`=1 at a rising edge appears with `vld_o`=1 after exactly two rising edges. A cycle with `vld_i`=0 yields `vld_o`=0 two edges later.
- R3: The phase, in units where 0x10000 is one pixel, is -0x8000 + floor(scale / (2*sub)). Here `sub_i` is 1 or 2 and `scale_i` is an unsigned 16.16 ratio.
- R4: When `cosited_i`=1, the value (sub-1)*0x8000/sub is added as well. This is 0x4000 for sub=2 and nothing for sub=1.
- R5: A phase p with 0 <= p <= 0x18000 gives `word_o` = 0x8000 | ((p >> 2) & 0x7FFE). Bit 15 is the trip bit.
- R6: A phase p < 0 gives `word_o` = ((p + 0x10000) >> 2) & 0x7FFE, with bit 15 clear.
- R7: A phase above 0x18000 gives `err_o`=1 and `word_o`=0x0000. A phase of exactly 0x18000 is legal.
- R8: A `sub_i` value other than 1 or 2 (codes 0 and 3) gives `err_o`=1 and `word_o`=0x0000, whatever the scale.
- R9: While `vld_o`=0, `word_o` and `err_o` keep the values of the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vld_i | input | 1 | Input sample qualifier |
| scale_i | input | SCALE_W (32) | Scale ratio, unsigned 16.16 |
| sub_i | input | 2 | Subsampling factor: 1 or 2 are legal |
| cosited_i | input | 1 | Chroma co-sited siting adjustment |
| vld_o | output | 1 | Result qualifier, two cycles after `vld_i` |
| word_o | output | 16 | Trip bit in bit 15, truncated phase fraction in bits 14:1, bit 0 zero |
| err_o | output | 1 | Phase out of range or illegal subsampling factor |

## Verification
The bench builds the unit with its default 32-bit scale input. It sweeps scale from 0 to 5.0 in steps of 1/256 pixel, for all four `sub_i` codes and both siting settings. It adds points right around the legal limits: 4.0 for sub=1, 7.0 for co-sited sub=2, 8.0 for plain sub=2, and the all-ones scale. This covers both signs of the phase, the exact 1.5 boundary, the wrap of negative values and the rejected subsampling codes. Bubbles in the valid stream cover the fixed latency and the hold of the outputs between results.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;

  localparam int FRAC_BITS = 16;
  localparam int ONE_PH    = 1 << FRAC_BITS;
  localparam int HALF_PH   = ONE_PH / 2;
  localparam int QTR_PH    = ONE_PH / 4;
  localparam int MAX_PH    = ONE_PH + HALF_PH;
  localparam int WORD_W    = 16;
  localparam int TRIP_POS  = WORD_W - 1;
  localparam int SUB_W     = 2;
  localparam logic [WORD_W-1:0] FRAC_MASK = 16'h7FFE;

  typedef enum logic [1:0] {
    SUBK_BAD = 2'd0,
    SUBK_ONE = 2'd1,
    SUBK_TWO = 2'd2
  } sub_kind_e;

  function automatic sub_kind_e decode_sub(input logic [SUB_W-1:0] s);
    case (s)
      2'd1:    return SUBK_ONE;
      2'd2:    return SUBK_TWO;
      default: return SUBK_BAD;
    endcase
  endfunction

endpackage

// File: rtl/scl_phase_sum.sv
module scl_phase_sum
  import scl_phase_pkg::*;
#(
  parameter int SCALE_W = 32,
  parameter int PH_W    = SCALE_W + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vld_i,
  input  logic [SCALE_W-1:0]     scale_i,
  input  logic [SUB_W-1:0]       sub_i,
  input  logic                   cosited_i,
  output logic                   vld_o,
  output logic signed [PH_W-1:0] sum_o,
  output logic                   bad_o
);

  localparam logic signed [PH_W-1:0] START_S = -PH_W'(HALF_PH);
  localparam logic signed [PH_W-1:0] SITE_S  = PH_W'(QTR_PH);

  sub_kind_e               kind;
  logic signed [PH_W-1:0]  site_add;
  logic signed [PH_W-1:0]  scale_add;
  logic signed [PH_W-1:0]  sum_d;
  logic                    bad_d;

  always_comb begin
    kind      = decode_sub(sub_i);
    site_add  = (cosited_i && kind == SUBK_TWO) ? SITE_S : '0;
    scale_add = (kind == SUBK_TWO) ? PH_W'(scale_i >> 2) : PH_W'(scale_i >> 1);
    sum_d     = START_S + site_add + scale_add;
    bad_d     = (kind == SUBK_BAD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      sum_o <= '0;
      bad_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        sum_o <= sum_d;
        bad_o <= bad_d;
      end
    end
  end

endmodule

// File: rtl/scl_phase_encode.sv
module scl_phase_encode
  import scl_phase_pkg::*;
#(
  parameter int PH_W = 34
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vld_i,
  input  logic signed [PH_W-1:0] sum_i,
  input  logic                   bad_i,
  output logic                   vld_o,
  output logic [WORD_W-1:0]      word_o,
  output logic                   err_o
);

  localparam logic signed [PH_W-1:0] ONE_S = PH_W'(ONE_PH);
  localparam logic signed [PH_W-1:0] LO_S  = -PH_W'(HALF_PH);
  localparam logic signed [PH_W-1:0] HI_S  = PH_W'(MAX_PH);

  logic                    neg;
  logic                    out_of_range;
  logic signed [PH_W-1:0]  wrapped;
  logic [WORD_W-1:0]       field;
  logic [WORD_W-1:0]       word_d;
  logic                    err_d;

  always_comb begin
    neg          = sum_i[PH_W-1];
    out_of_range = (sum_i < LO_S) || (sum_i > HI_S);
    err_d        = bad_i || out_of_range;
    wrapped      = neg ? (sum_i + ONE_S) : sum_i;
    field        = wrapped[WORD_W+1:2] & FRAC_MASK;
    word_d       = '0;
    if (!err_d) begin
      word_d           = field;
      word_d[TRIP_POS] = ~neg;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      word_o <= '0;
      err_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        word_o <= word_d;
        err_o  <= err_d;
      end
    end
  end

endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_phase_pkg::*;
#(
  parameter int SCALE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [1:0]         sub_i,
  input  logic               cosited_i,
  output logic               vld_o,
  output logic [15:0]        word_o,
  output logic               err_o
);

  localparam int PH_W = SCALE_W + 2;

  logic                   rst_meta_q;
  logic                   rst_sync_q;
  logic                   s1_vld;
  logic signed [PH_W-1:0] s1_sum;
  logic                   s1_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  scl_phase_sum #(
    .SCALE_W (SCALE_W),
    .PH_W    (PH_W)
  ) u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .vld_i     (vld_i),
    .scale_i   (scale_i),
    .sub_i     (sub_i),
    .cosited_i (cosited_i),
    .vld_o     (s1_vld),
    .sum_o     (s1_sum),
    .bad_o     (s1_bad)
  );

  scl_phase_encode #(
    .PH_W (PH_W)
  ) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .vld_i  (s1_vld),
    .sum_i  (s1_sum),
    .bad_i  (s1_bad),
    .vld_o  (vld_o),
    .word_o (word_o),
    .err_o  (err_o)
  );

endmodule

// File: rtl/scl_phase_calc_chk.sv
module scl_phase_calc_chk (
  input logic        clk_i,
  input logic        rst_sync,
  input logic        vld_i,
  input logic [1:0]  sub_i,
  input logic        vld_o,
  input logic [15:0] word_o,
  input logic        err_o
);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_sync)
    vld_i |=> ##1 vld_o); // R2

  AST_BUBBLE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_sync)
    !vld_i |=> ##1 !vld_o); // R2

  AST_ERR_CLEARS_WORD: assert property (@(posedge clk_i) disable iff (!rst_sync)
    err_o |-> word_o == 16'h0000); // R7

  AST_BAD_SUB_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_sync)
    (vld_i && (sub_i == 2'd0 || sub_i == 2'd3)) |=> ##1 err_o); // R8

  AST_TRIP_WORD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_sync)
    (vld_o && word_o[15]) |-> word_o[14:0] <= 15'h6000); // R5

  AST_WRAP_WORD_BAND: assert property (@(posedge clk_i) disable iff (!rst_sync)
    (vld_o && !err_o && !word_o[15]) |-> (word_o[14:13] == 2'b01)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_sync)
    !vld_o |-> ($stable(word_o) && $stable(err_o))); // R9

endmodule

bind scl_phase_calc scl_phase_calc_chk u_chk (
  .clk_i    (clk_i),
  .rst_sync (rst_sync_q),
  .vld_i    (vld_i),
  .sub_i    (sub_i),
  .vld_o    (vld_o),
  .word_o   (word_o),
  .err_o    (err_o)
);

// File: tb/tb_scl_phase_calc.sv
module tb_scl_phase_calc;

  localparam int SCALE_W = 32;

  logic               clk;
  logic               rst_n;
  logic               vld_i;
  logic [SCALE_W-1:0] scale_i;
  logic [1:0]         sub_i;
  logic               cosited_i;
  logic               vld_o;
  logic [15:0]        word_o;
  logic               err_o;

  int tests_run;
  int tests_fail;
  int cyc;
  int slot;
  bit done;

  bit          e1_v, e2_v;
  logic [15:0] e1_w, e2_w;
  bit          e1_e, e2_e;
  string       e1_t, e2_t;
  logic [15:0] last_w;
  bit          last_e;

  scl_phase_calc #(.SCALE_W(SCALE_W)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .vld_i     (vld_i),
    .scale_i   (scale_i),
    .sub_i     (sub_i),
    .cosited_i (cosited_i),
    .vld_o     (vld_o),
    .word_o    (word_o),
    .err_o     (err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    tests_run++;
    if (!ok) begin
      tests_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input longint scale, input int sub, input bit cos,
                       output logic [15:0] w, output bit e, output string tag);
    longint ph;
    w = 16'h0;
    if (sub != 1 && sub != 2) begin
      e = 1'b1; tag = "R8";
      return;
    end
    ph = -32768;
    if (cos) ph += (sub - 1) * 32768 / sub;
    ph += scale / (2 * sub);
    if (ph > 98304) begin
      e = 1'b1; tag = "R7";
      return;
    end
    e = 1'b0;
    if (ph < 0) begin
      w = 16'(((ph + 65536) >>> 2) & 32766);
      tag = (cos && sub == 2) ? "R4" : "R6";
    end else begin
      w = 16'(32768 | ((ph >>> 2) & 32766));
      tag = (cos && sub == 2) ? "R4" : ((ph == 98304) ? "R7" : "R5");
    end
    if (scale == 0) tag = "R3";
  endtask

  // Called just after a falling edge: check the result of two slots ago, then drive.
  task automatic step(input bit v, input longint scale, input int sub, input bit cos);
    logic [15:0] w;
    bit e;
    string t;
    check(vld_o == e2_v, "R2", "vld_o", longint'(vld_o), longint'(e2_v));
    if (e2_v) begin
      check(word_o == e2_w && err_o == e2_e, e2_t, "word/err",
            {word_o, 3'b0, err_o}, {e2_w, 3'b0, e2_e});
      last_w = word_o;
      last_e = err_o;
    end else if (slot % 7 == 0) begin
      check(word_o == last_w && err_o == last_e, "R9", "hold word/err",
            {word_o, 3'b0, err_o}, {last_w, 3'b0, last_e});
    end
    slot++;
    vld_i     = v;
    scale_i   = SCALE_W'(scale);
    sub_i     = 2'(sub);
    cosited_i = cos;
    e2_v = e1_v; e2_w = e1_w; e2_e = e1_e; e2_t = e1_t;
    if (v) model(scale, sub, cos, w, e, t);
    else begin w = 16'h0; e = 1'b0; t = "R2"; end
    e1_v = v; e1_w = w; e1_e = e; e1_t = t;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        tests_run++;
        tests_fail++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    longint edges [16] = '{0, 1, 3, 32'h4000, 32'h10000, 32'h3FFFF, 32'h40000,
                           32'h40001, 32'h40002, 32'h70003, 32'h70004, 32'h80003,
                           32'h80004, 32'h7FFFF, 32'hFFFFFFFF, 32'h20000};
    tests_run = 0; tests_fail = 0; slot = 1; done = 1'b0;
    e1_v = 0; e2_v = 0; e1_w = 0; e2_w = 0; e1_e = 0; e2_e = 0;
    last_w = 16'h0; last_e = 1'b0;
    vld_i = 0; scale_i = '0; sub_i = 2'd1; cosited_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(vld_o == 1'b0 && word_o == 16'h0 && err_o == 1'b0, "R1", "reset state",
          {vld_o, word_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(vld_o == 1'b0 && word_o == 16'h0 && err_o == 1'b0, "R1", "after release",
          {vld_o, word_o, err_o}, 0);

    // Named corner points: 4:1 down gives 1.5, 1:4 up gives -0.375.
    step(1, 32'h40000, 1, 0);
    step(1, 32'h4000, 1, 0);
    step(1, 32'h10000, 2, 1);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);

    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < 16; k++)
          step(1, edges[k], s, c[0]);

    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (longint sc = 0; sc <= 32'h50000; sc += 32'h100)
          step((slot % 5) != 3, sc, s, c[0]);

    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    finish_run();
  end

endmodule